// File: doc/BRIEF.md
# Zip/Unzip Bit Shuffle Unit

This combinational unit performs the two perfect-shuffle permutations on a 32-bit word. Zip interleaves the two halves of the operand. The lower half lands on the even result bits and the upper half lands on the odd result bits. Unzip is the inverse: it gathers the even bits into the lower half and the odd bits into the upper half. An execution pipeline places the unit beside its other single-cycle functional units and reads the result in the same cycle.

The permutation is built from a chain of masked swap stages. The stage shifts are 1, 2, 4 and 8. Each stage is switched on by the control bit whose weight equals its shift. The two standard operations use control value 15, which enables every stage. Any other control value below 16 gives a partial shuffle. Zip and unzip walk the stages in opposite orders, and that is why one undoes the other. A control value of 16 or more is illegal. The unit flags it and drives a zero result.

Top module: `zip_shuffle_unit`

## Requirements
- R1: With `opUnzip`=0 and `ctrlVal`=15, result bit 2i equals operand bit i, and result bit 2i+1 equals operand bit 16+i, for i from 0 to 15.
- R2: With `opUnzip`=1 and `ctrlVal`=15, result bit i equals operand bit 2i, and result bit 16+i equals operand bit 2i+1, for i from 0 to 15.
- R3: For every legal control value, unzip applied to the zip of x returns x, and zip applied to the unzip of x returns x. A legal shuffle never changes the number of set bits.
- R4: `ctrlVal`=0 returns the operand unchanged for both operations, and `legal` is 1.
- R5: A stage with shift s handles each bit j according to where j falls in its group of 4s bits. If j mod 4s lies in [2s,3s), the bit takes operand bit j-s. If j mod 4s lies in [s,2s), the bit takes operand bit j+s. All other bits pass through unchanged. A control value equal to a single power of two s (1, 2, 4 or 8) applies only that stage, under either operation.
- R6: Control bit k (weight 2^k, k=0..3) enables the stage with shift 2^k. Unzip applies the enabled stages in rising shift order. Zip applies them in falling shift order.
- R7: A control value of 16 to 31 drives `legal` to 0 and `result` to zero, whatever the operand and operation.
- R8: A control value of 0 to 15 drives `legal` to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opUnzip | input | 1 | 0 selects zip, 1 selects unzip |
| ctrlVal | input | 5 | stage-enable control; 15 for the standard operations |
| operand | input | 32 | word to shuffle |
| result | output | 32 | shuffled word, or zero when the control is illegal |
| legal | output | 1 | 1 when ctrlVal is below 16 |

## Verification
The assertions are immediate checks evaluated whenever the combinational inputs settle. They assume that every input carries a known 0/1 value. They skip any evaluation where an input is unknown, so the stimulus drives all three inputs from time zero and changes them only away from the sampling point. The sweep drives every one of the 32 control values under both operations with fixed and pseudo-random operands. It therefore covers the out-of-range controls that the population-count assertion is gated against.

// File: rtl/zipshuf_pkg.sv
package zipshuf_pkg;
  localparam int XLEN    = 32;
  localparam int LOG_X   = $clog2(XLEN);
  localparam int NSTAGE  = LOG_X - 1;   // shifts 1 .. XLEN/4
  localparam int CTRL_W  = LOG_X;       // wide enough to express illegal values
  localparam int HALF    = XLEN / 2;

  typedef struct packed {
    logic [NSTAGE-1:0] stageEn;
    logic              unzipMode;
    logic              legal;
  } shufStrobe_t;

  // destination field of the bits moved upward by a stage of shift s
  function automatic logic [XLEN-1:0] upperField(input int s);
    logic [XLEN-1:0] m;
    m = '0;
    for (int j = 0; j < XLEN; j++) begin
      if ((j % (4 * s)) >= 2 * s && (j % (4 * s)) < 3 * s) m[j] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/shuf_stage.sv
module shuf_stage
  import zipshuf_pkg::*;
#(
  parameter int SHIFT = 1
) (
  input  logic [XLEN-1:0] din,
  input  logic            en,
  output logic [XLEN-1:0] dout
);
  localparam logic [XLEN-1:0] UP_FIELD = upperField(SHIFT);
  localparam logic [XLEN-1:0] DN_FIELD = UP_FIELD >> SHIFT;
  localparam logic [XLEN-1:0] KEEP     = ~(UP_FIELD | DN_FIELD);

  logic [XLEN-1:0] swapped;

  always_comb begin
    swapped = (din & KEEP) | ((din << SHIFT) & UP_FIELD) | ((din >> SHIFT) & DN_FIELD);
    dout    = en ? swapped : din;
  end

  always_comb begin
    if (!$isunknown({din, en})) begin
      // R5: bits outside both moving fields never change
      p_keep_outside_r5: assert (((dout ^ din) & KEEP) == '0)
        else $error("stage %0d altered a fixed bit", SHIFT);
      // R3: a stage is a permutation, so the set-bit count holds
      p_count_kept_r3: assert ($countones(dout) == $countones(din))
        else $error("stage %0d changed popcount", SHIFT);
      // R6: a disabled stage is transparent
      p_idle_pass_r6: assert (en || dout == din)
        else $error("disabled stage %0d moved bits", SHIFT);
    end
  end
endmodule

// File: rtl/shuf_ctrl.sv
module shuf_ctrl
  import zipshuf_pkg::*;
(
  input  logic              opUnzip,
  input  logic [CTRL_W-1:0] ctrlVal,
  output shufStrobe_t       strobe
);
  always_comb begin
    strobe.legal     = ~ctrlVal[CTRL_W-1];
    strobe.unzipMode = opUnzip;
    strobe.stageEn   = strobe.legal ? ctrlVal[NSTAGE-1:0] : '0;
  end

  always_comb begin
    if (!$isunknown({opUnzip, ctrlVal})) begin
      p_legal_range_r8: assert (strobe.legal == (int'(ctrlVal) < HALF))
        else $error("legal flag wrong for ctrl %0d", ctrlVal);
      p_no_stage_illegal_r7: assert (strobe.legal || $countones(strobe.stageEn) == 0)
        else $error("stage enabled for illegal ctrl %0d", ctrlVal);
    end
  end
endmodule

// File: rtl/shuf_datapath.sv
module shuf_datapath
  import zipshuf_pkg::*;
(
  input  logic [XLEN-1:0] operand,
  input  shufStrobe_t     strobe,
  output logic [XLEN-1:0] result
);
  // unzip chain: rising shifts; zip chain: falling shifts
  for (genvar p = 0; p < NSTAGE; p++) begin : gUp
    logic [XLEN-1:0] stgIn, stgOut;
    if (p == 0) begin : gFirst
      assign stgIn = operand;
    end else begin : gNext
      assign stgIn = gUp[p-1].stgOut;
    end
    shuf_stage #(.SHIFT(1 << p)) uStage (
      .din(stgIn), .en(strobe.stageEn[p]), .dout(stgOut));
  end

  for (genvar p = 0; p < NSTAGE; p++) begin : gDn
    localparam int IDX = NSTAGE - 1 - p;
    logic [XLEN-1:0] stgIn, stgOut;
    if (p == 0) begin : gFirst
      assign stgIn = operand;
    end else begin : gNext
      assign stgIn = gDn[p-1].stgOut;
    end
    shuf_stage #(.SHIFT(1 << IDX)) uStage (
      .din(stgIn), .en(strobe.stageEn[IDX]), .dout(stgOut));
  end

  always_comb begin
    if (!strobe.legal)        result = '0;
    else if (strobe.unzipMode) result = gUp[NSTAGE-1].stgOut;
    else                       result = gDn[NSTAGE-1].stgOut;
  end

  always_comb begin
    if (!$isunknown({operand, strobe})) begin
      p_bypass_r4: assert (!(strobe.legal && strobe.stageEn == '0) || result == operand)
        else $error("no-stage shuffle altered data");
    end
  end
endmodule

// File: rtl/zip_shuffle_unit.sv
module zip_shuffle_unit
  import zipshuf_pkg::*;
(
  input  logic              opUnzip,
  input  logic [CTRL_W-1:0] ctrlVal,
  input  logic [XLEN-1:0]   operand,
  output logic [XLEN-1:0]   result,
  output logic              legal
);
  shufStrobe_t strobe;

  shuf_ctrl uCtrl (.opUnzip(opUnzip), .ctrlVal(ctrlVal), .strobe(strobe));
  shuf_datapath uPath (.operand(operand), .strobe(strobe), .result(result));

  assign legal = strobe.legal;

  always_comb begin
    if (!$isunknown({opUnzip, ctrlVal, operand})) begin
      p_zero_illegal_r7: assert (legal || result == '0)
        else $error("illegal ctrl produced nonzero result");
      p_popcount_r3: assert (!legal || $countones(result) == $countones(operand))
        else $error("legal shuffle changed popcount");
    end
  end
endmodule

// File: tb/test_zip_shuffle_unit.sv
module test_zip_shuffle_unit;
  logic        clk = 1'b0;
  logic        opUnzip = 1'b0;
  logic [4:0]  ctrlVal = 5'd0;
  logic [31:0] operand = 32'd0;
  logic [31:0] result;
  logic        legal;
  int nRun = 0, nFail = 0;
  bit done = 0;

  always #4 clk = ~clk;   // 125 MHz

  zip_shuffle_unit i_zip_shuffle_unit (
    .opUnzip(opUnzip), .ctrlVal(ctrlVal), .operand(operand),
    .result(result), .legal(legal));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: op=%0d ctrl=%0d in=%h got %h expected %h",
               req, opUnzip, ctrlVal, operand, act, exp);
    end
  endtask

  task automatic apply(input logic u, input logic [4:0] c, input logic [31:0] x);
    @(negedge clk);
    opUnzip = u; ctrlVal = c; operand = x;
    #2;
  endtask

  // one stage per R5
  function automatic logic [31:0] stageRef(input logic [31:0] x, input int s);
    logic [31:0] y;
    for (int j = 0; j < 32; j++) begin
      int r;
      r = j % (4 * s);
      if (r >= 2 * s && r < 3 * s)  y[j] = x[j - s];
      else if (r >= s && r < 2 * s) y[j] = x[j + s];
      else                           y[j] = x[j];
    end
    return y;
  endfunction

  // ordering per R6, legality per R7
  function automatic logic [31:0] modelRef(input logic u, input logic [4:0] c, input logic [31:0] x);
    logic [31:0] y;
    y = x;
    if (c >= 16) return 32'd0;
    for (int k = 0; k < 4; k++) begin
      int kk;
      kk = u ? k : 3 - k;
      if (c[kk]) y = stageRef(y, 1 << kk);
    end
    return y;
  endfunction

  function automatic logic [31:0] zipFull(input logic [31:0] x);
    logic [31:0] y;
    for (int i = 0; i < 16; i++) begin
      y[2*i]   = x[i];
      y[2*i+1] = x[16+i];
    end
    return y;
  endfunction

  function automatic logic [31:0] unzipFull(input logic [31:0] x);
    logic [31:0] y;
    for (int i = 0; i < 16; i++) begin
      y[i]    = x[2*i];
      y[16+i] = x[2*i+1];
    end
    return y;
  endfunction

  initial begin
    logic [31:0] pats [0:7];
    pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'h0000_FFFF;
    pats[3] = 32'hFFFF_0000; pats[4] = 32'h5555_5555; pats[5] = 32'h0000_0001;
    pats[6] = 32'h8000_0000; pats[7] = 32'h1234_5678;

    // R4: idle state after power-up
    apply(0, 0, 32'hDEAD_BEEF);
    check("R4 zip ctrl0", result, 32'hDEAD_BEEF);
    check("R4 legal", {31'd0, legal}, 32'd1);
    apply(1, 0, 32'hCAFE_F00D);
    check("R4 unzip ctrl0", result, 32'hCAFE_F00D);

    // R1 / R2: standard operations
    for (int n = 0; n < 40; n++) begin
      logic [31:0] x;
      x = (n < 8) ? pats[n] : $urandom;
      apply(0, 15, x);
      check("R1 zip", result, zipFull(x));
      apply(1, 15, x);
      check("R2 unzip", result, unzipFull(x));
    end
    apply(0, 15, 32'h0000_0002);
    check("R1 bit1->bit2", result, 32'h0000_0004);
    apply(0, 15, 32'h0001_0000);
    check("R1 bit16->bit1", result, 32'h0000_0002);

    // R5: single stages
    for (int k = 0; k < 4; k++) begin
      for (int n = 0; n < 8; n++) begin
        apply(0, 5'(1 << k), pats[n]);
        check("R5 single zip", result, stageRef(pats[n], 1 << k));
        apply(1, 5'(1 << k), pats[n]);
        check("R5 single unzip", result, stageRef(pats[n], 1 << k));
      end
    end

    // R6 R7 R8: sweep every control value under both operations
    for (int c = 0; c < 32; c++) begin
      for (int u = 0; u < 2; u++) begin
        for (int n = 0; n < 12; n++) begin
          logic [31:0] x;
          x = (n < 8) ? pats[n] : $urandom;
          apply(u[0], 5'(c), x);
          check(c < 16 ? "R6 order" : "R7 zero", result, modelRef(u[0], 5'(c), x));
          check(c < 16 ? "R8 legal" : "R7 illegal", {31'd0, legal}, {31'd0, c < 16});
        end
      end
    end

    // R3: round trips
    for (int n = 0; n < 300; n++) begin
      logic [31:0] x, mid;
      logic [4:0]  c;
      x = $urandom;
      c = 5'($urandom_range(0, 15));
      if (n < 150) c = 5'd15;
      apply(0, c, x);
      mid = result;
      apply(1, c, mid);
      check("R3 unzip(zip)", result, x);
      apply(1, c, x);
      mid = result;
      apply(0, c, mid);
      check("R3 zip(unzip)", result, x);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule